// File: doc/BRIEF.md
# Shared Interrupt Controller with Per-CPU Mailboxes

This block gathers interrupt requests for a cluster of CPUs. A handful of level-sensitive device lines are synchronized and shown in a shared raw status word. A second raw word holds mailbox bits, two per CPU. Any CPU can raise those bits to interrupt another CPU, and the receiving CPU clears them once it has handled them. Each CPU has its own enable words. The controller ANDs the raw state with those enables to form that CPU's source words, and drives one interrupt line per CPU from them.

Software reaches the block through a plain 32-bit register bus. A read returns its data one cycle after it is requested. The address map is derived from the reported bit count. Every register bank has a plain form, a write-ones-to-set form and a write-ones-to-clear form. Because of the set and clear forms, no read-modify-write sequence is needed when several CPUs share one bank.

Top module: `irqMboxCtl`

## Requirements
- R1: A read of byte offset 0 returns NUM_BITS (64 by default). Read data for a request sampled at clock edge E is valid on `regRdata` after E and stays valid until the next edge.
- R2: The bank stride is S = 8*(1+(NUM_BITS-1)/64), which is 8 by default. The shared banks are at 8 (raw), 8+S (raw set) and 8+2S (raw clear). CPU n's banks are at 8+3S (source), 8+4S (enable), 8+5S (enable set) and 8+6S (enable clear), each plus n*4*S. Word 0 of a bank is at the bank offset and word 1 is at the bank offset plus 4.
- R3: Raw word 0 bits [NUM_DEV-1:0] (4 by default) follow `devIrq` after a two-flop synchronizer. Writes to raw word 0 have no effect.
- R4: A write to the plain raw word 1 or to a plain enable word loads the written value. Enable word 0 keeps NUM_DEV bits. Enable word 1 and raw word 1 keep 2*NUM_CPUS bits. All higher bits read as zero.
- R5: A write to the raw word 1 set form sets the mailbox bits written as one. A write to the clear form clears them. Bits written as zero keep their value. Mailbox m of CPU n is bit 2n+m.
- R6: A write to the enable set or clear form of CPU n sets or clears, for that CPU only, the enable bits written as one.
- R7: CPU n's source word 0 equals raw word 0 AND its enable word 0. Its source word 1 equals raw word 1 AND its enable word 1, limited to bits 2n and 2n+1.
- R8: `cpuIrq[n]` is the OR of CPU n's source words, taken through one register. It changes on the edge after the edge that changed the state.
- R9: After reset, the mailbox bits, all enables, `cpuIrq` and `regRdata` are zero.
- R10: Reads of unmapped offsets, unaligned offsets and the set/clear forms return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write request this cycle |
| regRd | input | 1 | Read request this cycle |
| regAddr | input | ADDR_W | Byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| devIrq | input | NUM_DEV | Asynchronous level device interrupt lines |
| cpuIrq | output | NUM_CPUS | One interrupt request per CPU |

## Verification
The embedded properties check the mailbox set and clear semantics on every cycle. They confirm that set and clear touch only the bits written as one, that idle cycles return zero read data, that decode produces a read kind only on a read request, and that the interrupt lines stay low whenever every enable is off. The address map, the per-CPU isolation of enables and mailbox bits, the synchronizer delay and the exact one-cycle lag of `cpuIrq` can only be shown by the bench. It drives mixed random and directed sequences and compares register reads and interrupt lines against its own model.

// File: rtl/icPkg.sv
package icPkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_RAW, TGT_EN} wrTarget_e;
  typedef enum logic [1:0] {ACT_LD, ACT_SET, ACT_CLR} wrAction_e;
  typedef enum logic [2:0] {RD_NONE, RD_COUNT, RD_RAW, RD_SRC, RD_EN} rdKind_e;

  typedef struct packed {
    wrTarget_e tgt;
    wrAction_e act;
    rdKind_e   rd;
    logic      mbox;
    logic [3:0] cpu;
  } icStrobe_t;

  function automatic int bankStride(int nb);
    return 8 * (1 + (nb - 1) / 64);
  endfunction
endpackage

// File: rtl/icCtrl.sv
module icCtrl
  import icPkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_BITS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output icStrobe_t         strb
);
  localparam int BASE       = 8;
  localparam int STRIDE     = bankStride(NUM_BITS);
  localparam int CPU_STRIDE = 4 * STRIDE;

  int addrI, shifted, grp, sub, off;
  logic aligned;

  always_comb begin
    strb    = '{tgt: TGT_NONE, act: ACT_LD, rd: RD_NONE, mbox: 1'b0, cpu: '0};
    addrI   = 32'(regAddr);
    shifted = addrI + STRIDE - BASE;
    grp     = shifted / CPU_STRIDE;
    sub     = (shifted % CPU_STRIDE) / STRIDE;
    off     = shifted % STRIDE;
    aligned = (addrI >= BASE) && (off == 0 || off == 4);
    strb.mbox = (off == 4);
    if (addrI == 0) begin
      if (regRd) strb.rd = RD_COUNT;
    end else if (aligned && grp == 0) begin
      // shared raw banks: sub 1 plain, 2 set, 3 clear
      unique case (sub)
        1: begin
          if (regRd) strb.rd = RD_RAW;
          if (regWr) begin strb.tgt = TGT_RAW; strb.act = ACT_LD; end
        end
        2: if (regWr) begin strb.tgt = TGT_RAW; strb.act = ACT_SET; end
        3: if (regWr) begin strb.tgt = TGT_RAW; strb.act = ACT_CLR; end
        default: ;
      endcase
    end else if (aligned && grp - 1 < NUM_CPUS) begin
      strb.cpu = 4'(grp - 1);
      unique case (sub)
        0: if (regRd) strb.rd = RD_SRC;
        1: begin
          if (regRd) strb.rd = RD_EN;
          if (regWr) begin strb.tgt = TGT_EN; strb.act = ACT_LD; end
        end
        2: if (regWr) begin strb.tgt = TGT_EN; strb.act = ACT_SET; end
        3: if (regWr) begin strb.tgt = TGT_EN; strb.act = ACT_CLR; end
        default: ;
      endcase
    end
  end

  // R10
  rd_only_on_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd != RD_NONE) |-> regRd);
endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_BITS = 64,
  parameter int NUM_DEV  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  icStrobe_t           strb,
  input  logic [31:0]         wdata,
  input  logic [NUM_DEV-1:0]  devIrq,
  output logic [31:0]         rdata,
  output logic [NUM_CPUS-1:0] cpuIrq
);
  localparam int MB_W = 2 * NUM_CPUS;

  logic [NUM_DEV-1:0] devMeta, devSync;
  logic [MB_W-1:0]    rawMbox;
  logic [NUM_DEV-1:0] enDev  [NUM_CPUS];
  logic [MB_W-1:0]    enMbox [NUM_CPUS];
  logic [NUM_DEV-1:0] srcDev [NUM_CPUS];
  logic [MB_W-1:0]    srcMbox[NUM_CPUS];
  logic [NUM_CPUS-1:0] irqNext;
  logic [31:0] rdNext;
  logic enAllOff;

  function automatic logic [31:0] upd(logic [31:0] cur, logic [31:0] w, wrAction_e act);
    case (act)
      ACT_SET: return cur | w;
      ACT_CLR: return cur & ~w;
      default: return w;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devMeta <= '0;
      devSync <= '0;
    end else begin
      devMeta <= devIrq;
      devSync <= devMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawMbox <= '0;
    else if (strb.tgt == TGT_RAW && strb.mbox)
      rawMbox <= MB_W'(upd(32'(rawMbox), wdata, strb.act));
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : gCpu
    localparam logic [MB_W-1:0] OWN = MB_W'(3) << (2 * c);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enDev[c]  <= '0;
        enMbox[c] <= '0;
      end else if (strb.tgt == TGT_EN && strb.cpu == 4'(c)) begin
        if (strb.mbox) enMbox[c] <= MB_W'(upd(32'(enMbox[c]), wdata, strb.act));
        else           enDev[c]  <= NUM_DEV'(upd(32'(enDev[c]), wdata, strb.act));
      end
    end

    assign srcDev[c]  = devSync & enDev[c];
    assign srcMbox[c] = rawMbox & enMbox[c] & OWN;
    assign irqNext[c] = (|srcDev[c]) | (|srcMbox[c]);
  end

  always_comb begin
    enAllOff = 1'b1;
    rdNext   = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (|enDev[c] || |enMbox[c]) enAllOff = 1'b0;
      if (strb.cpu == 4'(c)) begin
        if (strb.rd == RD_EN)  rdNext = strb.mbox ? 32'(enMbox[c])  : 32'(enDev[c]);
        if (strb.rd == RD_SRC) rdNext = strb.mbox ? 32'(srcMbox[c]) : 32'(srcDev[c]);
      end
    end
    if (strb.rd == RD_COUNT) rdNext = 32'(NUM_BITS);
    if (strb.rd == RD_RAW)   rdNext = strb.mbox ? 32'(rawMbox) : 32'(devSync);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata  <= '0;
      cpuIrq <= '0;
    end else begin
      rdata  <= rdNext;
      cpuIrq <= irqNext;
    end
  end

  // R5
  mbox_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tgt == TGT_RAW && strb.act == ACT_SET && strb.mbox)
    |=> ((rawMbox & $past(wdata[MB_W-1:0])) == $past(wdata[MB_W-1:0])));
  // R5
  mbox_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tgt == TGT_RAW && strb.act == ACT_CLR && strb.mbox)
    |=> ((rawMbox & $past(wdata[MB_W-1:0])) == '0));
  // R5
  mbox_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tgt == TGT_RAW && strb.act != ACT_LD && strb.mbox)
    |=> ((rawMbox & ~$past(wdata[MB_W-1:0])) == ($past(rawMbox) & ~$past(wdata[MB_W-1:0]))));
  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd == RD_NONE) |=> (rdata == '0));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    enAllOff |=> (cpuIrq == '0));
endmodule

// File: rtl/irqMboxCtl.sv
module irqMboxCtl
  import icPkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_BITS = 64,
  parameter int NUM_DEV  = 4,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_DEV-1:0]  devIrq,
  output logic [NUM_CPUS-1:0] cpuIrq
);
  icStrobe_t strb;

  icCtrl #(.NUM_CPUS(NUM_CPUS), .NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .strb(strb)
  );

  icDatapath #(.NUM_CPUS(NUM_CPUS), .NUM_BITS(NUM_BITS), .NUM_DEV(NUM_DEV)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(regWdata),
    .devIrq(devIrq), .rdata(regRdata), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/tb_irqMboxCtl.sv
`timescale 1ns/1ps
module tb_irqMboxCtl;
  localparam int NC = 4, ND = 4, AW = 12;

  logic clk = 0, rstN = 0, regWr = 0, regRd = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [ND-1:0] devIrq = '0;
  logic [NC-1:0] cpuIrq;

  int checks = 0, fails = 0;

  logic [7:0] mbM;
  logic [3:0] devM;
  logic [3:0] enDevM [NC];
  logic [7:0] enMbM  [NC];

  irqMboxCtl dut (.clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .devIrq(devIrq), .cpuIrq(cpuIrq));

  always #2.5 clk = ~clk;

  // R2 address map with stride 8
  function automatic logic [AW-1:0] aShared(int k, int w);
    return AW'(8 + 8 * k + 4 * w);
  endfunction
  function automatic logic [AW-1:0] aCpu(int k, int n, int w);
    return AW'(8 + 8 * k + 32 * n + 4 * w);
  endfunction
  function automatic logic [31:0] expSrc(int n, int w);
    if (w == 0) return 32'(devM & enDevM[n]);
    return 32'(mbM & enMbM[n] & (8'd3 << (2 * n)));
  endfunction
  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] r;
    for (int n = 0; n < NC; n++) r[n] = |expSrc(n, 0) | |expSrc(n, 1);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1; regAddr = a;
    @(negedge clk); regRd = 0; d = regRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    mbM = 0; devM = 0;
    for (int n = 0; n < NC; n++) begin enDevM[n] = 0; enMbM[n] = 0; end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R9 irq after reset", 32'(cpuIrq), 0);
    chk("R9 rdata after reset", regRdata, 0);
    rd(0, v); chk("R1 bit count", v, 64);
    rd(aShared(0, 1), v); chk("R9 mailbox reset", v, 0);
    rd(aCpu(4, 3, 1), v); chk("R9 enable reset", v, 0);
    rd(4, v); chk("R10 unmapped offset 4", v, 0);
    rd(10, v); chk("R10 unaligned", v, 0);
    rd(12'h300, v); chk("R10 beyond last cpu", v, 0);

    // mailbox of CPU1
    wr(aShared(1, 1), 32'h0C); mbM = 8'h0C;
    rd(aShared(0, 1), v); chk("R5 set mailbox", v, 32'h0C);
    rd(aShared(1, 1), v); chk("R10 set alias reads zero", v, 0);
    wr(aCpu(5, 1, 1), 32'hFFFF_FFFF); enMbM[1] = 8'hFF;
    chk("R8 no irq yet", 32'(cpuIrq), 0);
    @(negedge clk);
    chk("R8 irq one cycle later", 32'(cpuIrq), 32'b0010);
    rd(aCpu(4, 1, 1), v); chk("R4 R6 enable word1 width", v, 32'hFF);
    rd(aCpu(3, 1, 1), v); chk("R7 own mailbox source", v, 32'h0C);
    wr(aCpu(5, 0, 1), 32'hFF); enMbM[0] = 8'hFF;
    rd(aCpu(3, 0, 1), v); chk("R7 foreign bits hidden", v, 0);
    wr(aShared(2, 1), 32'h04); mbM = 8'h08;
    rd(aShared(0, 1), v); chk("R5 clear mailbox", v, 32'h08);

    // device lines
    devIrq = 4'b0101; devM = 4'b0101;
    repeat (3) @(negedge clk);
    rd(aShared(0, 0), v); chk("R3 synchronized device", v, 32'h5);
    wr(aShared(0, 0), 32'hF);
    rd(aShared(0, 0), v); chk("R3 raw word0 write ignored", v, 32'h5);
    wr(aCpu(4, 2, 0), 32'hFFFF_FFFF); enDevM[2] = 4'hF;
    rd(aCpu(4, 2, 0), v); chk("R4 enable word0 width", v, 32'hF);
    rd(aCpu(3, 2, 0), v); chk("R7 device source", v, 32'h5);
    wr(aCpu(6, 2, 0), 32'h1); enDevM[2] = 4'hE;
    rd(aCpu(4, 2, 0), v); chk("R6 enable clear", v, 32'hE);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(aShared(0, 1), v); chk("R10 unmapped write no effect", v, 32'(mbM));
    @(negedge clk);
    chk("R8 irq lines", 32'(cpuIrq), 32'(expIrq()));

    for (int i = 0; i < 400; i++) begin
      int op, n, w;
      logic [31:0] d;
      op = $urandom_range(0, 6); n = $urandom_range(0, NC - 1);
      w = $urandom_range(0, 1); d = $urandom;
      case (op)
        0: begin wr(aShared(0, 1), d); mbM = d[7:0]; end
        1: begin wr(aShared(1, 1), d); mbM = mbM | d[7:0]; end
        2: begin wr(aShared(2, 1), d); mbM = mbM & ~d[7:0]; end
        3: begin wr(aCpu(4, n, w), d);
                 if (w == 0) enDevM[n] = d[3:0]; else enMbM[n] = d[7:0]; end
        4: begin wr(aCpu(5, n, w), d);
                 if (w == 0) enDevM[n] |= d[3:0]; else enMbM[n] |= d[7:0]; end
        5: begin wr(aCpu(6, n, w), d);
                 if (w == 0) enDevM[n] &= ~d[3:0]; else enMbM[n] &= ~d[7:0]; end
        default: begin devIrq = d[3:0]; devM = d[3:0]; repeat (2) @(negedge clk); end
      endcase
      @(negedge clk);
      chk("R8 random irq", 32'(cpuIrq), 32'(expIrq()));
      rd(aCpu(3, n, w), v); chk("R7 random source", v, expSrc(n, w));
      if (i % 4 == 0) begin
        rd(aShared(0, 1), v); chk("R5 random mailbox", v, 32'(mbM));
        rd(aCpu(4, n, 1), v); chk("R6 random enable", v, 32'(enMbM[n]));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule